// File: doc/BRIEF.md
# Cache line writeback-invalidate controller

This block carries out a maintenance operation on one line of a small direct-mapped write-back L1 data cache. A request brings an effective byte address. The block looks up the line that would hold that byte. On a hit to a modified line, it sends the line to memory and then drops it from the cache. On a hit to a clean line, it only drops the line. On a miss, it changes nothing and fetches nothing. The tag, state and line data arrays sit inside the block. A preload port lets a test environment fill them.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the controller is idle. Holding `req_valid` high while busy applies back-pressure and is harmless: the request waits and is not sampled. The memory side is also valid/ready. `wb_valid`, `wb_addr` and `wb_data` hold steady until the memory raises `wb_ready`.

Each operation ends with a one-cycle `ack` pulse. The pulse carries the hit result, whether a writeback happened, and an echo of the request's base-update flag. That flag is echoed whatever the lookup outcome, so a caller that updates an address register never waits on the cache result.

Top module: `line_wbinv_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `ack` and `wb_valid` are 0, and every line is invalid, so any request misses.
- R2: The line index is address bits [8:5] and the tag is bits [31:9]. A lookup hits only when the indexed line is valid and its stored tag equals the address tag.
- R3: A hit on a clean line clears the valid bit and never raises `wb_valid`. It acks with `ack_hit`=1 and `ack_wb`=0, with `ack` high in the second cycle after the accept edge.
- R4: A hit on a dirty line raises `wb_valid` in the second cycle after the accept edge. It shows the line-aligned address (low 5 bits zero) and the full line data.
- R5: `wb_addr` and `wb_data` hold steady while `wb_ready` is low. After the edge where `wb_valid` and `wb_ready` are both high, the line is invalid and not dirty, and `ack` follows in the next cycle with `ack_hit`=1 and `ack_wb`=1.
- R6: A miss, including one on an invalid line, writes no memory and alters no cache state. It acks with `ack_hit`=0 and `ack_wb`=0.
- R7: `ack_upd` during the ack pulse equals the `req_upd` value that was accepted, whatever the hit, miss, clean or dirty outcome.
- R8: `req_ready` is low from the edge after an accept until the ack pulse has ended. A request held during that time is not taken.
- R9: `ack` is a single-cycle pulse.
- R10: While idle, a `pl_en` cycle writes the tag, valid bit, dirty bit and data of line `pl_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 32 | Effective byte address |
| req_upd | input | 1 | Addressing mode updates a base register |
| ack | output | 1 | One-cycle completion pulse |
| ack_hit | output | 1 | Line was present |
| ack_wb | output | 1 | Line was written back |
| ack_upd | output | 1 | Base update done (echo of req_upd) |
| wb_valid | output | 1 | Writeback line offered to memory |
| wb_ready | input | 1 | Memory takes the line |
| wb_addr | output | 32 | Line-aligned writeback address |
| wb_data | output | 256 | Writeback line data |
| pl_en | input | 1 | Preload write enable |
| pl_idx | input | 4 | Preload line index |
| pl_tag | input | 23 | Preload tag |
| pl_valid | input | 1 | Preload valid bit |
| pl_dirty | input | 1 | Preload dirty bit |
| pl_data | input | 256 | Preload line data |

## Verification
Misses and clean hits produce `ack` in the second cycle after the accept edge. A dirty hit offers the line in that same second cycle, and `ack` comes one cycle after the memory handshake, which is 3 plus the ready delay. The bench drives and samples on the falling edge. It counts falling edges from the accept edge to the pulse and compares that count with the value the requirement predicts. While a writeback waits, it checks the memory port on every falling edge. Whether a miss or a busy-time request left the cache untouched is checked by a later request to the same line, which must still hit.

// File: rtl/wbinv_pkg.sv
package wbinv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_DONE = 2'd3
  } wbinv_state_e;
endpackage

// File: rtl/wbinv_tag_store.sv
module wbinv_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pl_en,
  input  logic [IDX_W-1:0] pl_idx,
  input  logic [TAG_W-1:0] pl_tag,
  input  logic             pl_valid,
  input  logic             pl_dirty,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] val_q;
  logic [LINES-1:0] drt_q;

  always_ff @(posedge clk) begin
    if (pl_en) tag_q[pl_idx] <= pl_tag;
  end

  // valid/dirty: invalidation wins over preload of the same line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      drt_q <= '0;
    end else begin
      if (pl_en) begin
        val_q[pl_idx] <= pl_valid;
        drt_q[pl_idx] <= pl_dirty;
      end
      if (inv_en) begin
        val_q[rd_idx] <= 1'b0;
        drt_q[rd_idx] <= 1'b0;
      end
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = val_q[rd_idx];
  assign rd_dirty = drt_q[rd_idx];
endmodule

// File: rtl/wbinv_line_store.sv
module wbinv_line_store #(
  parameter int LINES  = 16,
  parameter int LINE_W = 256,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              pl_en,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [LINE_W-1:0] pl_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_data
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (pl_en) mem_q[pl_idx] <= pl_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/wbinv_seq.sv
module wbinv_seq
  import wbinv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_upd,
  input  logic              lk_hit,
  input  logic              lk_dirty,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              inv_en,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic              ack,
  output logic              ack_hit,
  output logic              ack_wb,
  output logic              ack_upd
);
  wbinv_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              upd_q, hit_q, wbd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      upd_q   <= 1'b0;
      hit_q   <= 1'b0;
      wbd_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          upd_q   <= req_upd;
          state_q <= ST_LOOK;
        end
        ST_LOOK: begin
          hit_q   <= lk_hit;
          wbd_q   <= lk_hit && lk_dirty;
          state_q <= (lk_hit && lk_dirty) ? ST_WB : ST_DONE;
        end
        ST_WB:   if (wb_ready) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cur_addr  = addr_q;
  assign wb_valid  = (state_q == ST_WB);
  assign inv_en    = ((state_q == ST_LOOK) && lk_hit && !lk_dirty)
                   || ((state_q == ST_WB) && wb_ready);
  assign ack       = (state_q == ST_DONE);
  assign ack_hit   = ack && hit_q;
  assign ack_wb    = ack && wbd_q;
  assign ack_upd   = ack && upd_q;
endmodule

// File: rtl/line_wbinv_ctrl.sv
module line_wbinv_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_upd,
  output logic              ack,
  output logic              ack_hit,
  output logic              ack_wb,
  output logic              ack_upd,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data,
  input  logic              pl_en,
  input  logic [IDX_W-1:0]  pl_idx,
  input  logic [TAG_W-1:0]  pl_tag,
  input  logic              pl_valid,
  input  logic              pl_dirty,
  input  logic [LINE_W-1:0] pl_data
);
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag, rd_tag;
  logic              rd_valid, rd_dirty, lk_hit, inv_en;

  assign cur_idx = cur_addr[OFS_W +: IDX_W];
  assign cur_tag = cur_addr[ADDR_W-1 -: TAG_W];
  assign lk_hit  = rd_valid && (rd_tag == cur_tag);
  assign wb_addr = {cur_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  wbinv_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .pl_en(pl_en), .pl_idx(pl_idx), .pl_tag(pl_tag),
    .pl_valid(pl_valid), .pl_dirty(pl_dirty),
    .inv_en(inv_en), .rd_idx(cur_idx),
    .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty)
  );

  wbinv_line_store #(.LINES(LINES), .LINE_W(LINE_W)) u_data (
    .clk(clk), .pl_en(pl_en), .pl_idx(pl_idx), .pl_data(pl_data),
    .rd_idx(cur_idx), .rd_data(wb_data)
  );

  wbinv_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_upd(req_upd),
    .lk_hit(lk_hit), .lk_dirty(rd_dirty),
    .cur_addr(cur_addr), .inv_en(inv_en),
    .wb_valid(wb_valid), .wb_ready(wb_ready),
    .ack(ack), .ack_hit(ack_hit), .ack_wb(ack_wb), .ack_upd(ack_upd)
  );
endmodule

// File: rtl/wbinv_chk.sv
module wbinv_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              ack,
  input logic              ack_hit,
  input logic              ack_wb,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [LINE_W-1:0] wb_data
);
  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r5_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));

  a_r5_ack_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> (ack && ack_hit && ack_wb));

  a_r6_no_wb_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_hit) |-> !ack_wb);

  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_busy_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !req_ready);

  a_r4_wb_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_addr[4:0] == 5'd0));
endmodule

bind line_wbinv_ctrl wbinv_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_wbinv_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ack(ack), .ack_hit(ack_hit), .ack_wb(ack_wb),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/test_line_wbinv_ctrl.sv
module test_line_wbinv_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [22:0] WRONG_TAG = 23'h0777;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_upd = 1'b0, wb_ready = 1'b0;
  logic [31:0] req_addr = '0;
  logic pl_en = 1'b0, pl_valid = 1'b0, pl_dirty = 1'b0;
  logic [3:0] pl_idx = '0;
  logic [22:0] pl_tag = '0;
  logic [255:0] pl_data = '0;
  logic req_ready, ack, ack_hit, ack_wb, ack_upd, wb_valid;
  logic [31:0] wb_addr;
  logic [255:0] wb_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_wbinv_ctrl i_line_wbinv_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_upd(req_upd), .ack(ack), .ack_hit(ack_hit),
    .ack_wb(ack_wb), .ack_upd(ack_upd), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .pl_en(pl_en), .pl_idx(pl_idx),
    .pl_tag(pl_tag), .pl_valid(pl_valid), .pl_dirty(pl_dirty), .pl_data(pl_data)
  );

  function automatic logic [255:0] line_pat(input int i);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'hC0DE0000 ^ (i << 8) ^ k;
    return v;
  endfunction

  function automatic logic [22:0] good_tag(input int i);
    return 23'h1000 + 23'(i);
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request; check completion timing, flags and the memory port.
  task automatic op(input logic [31:0] addr, input logic upd, input int dly,
                    input logic e_hit, input logic e_wb,
                    input bit stray, input logic [31:0] stray_addr, input string tag);
    int cyc = 0, wcnt = 0;
    bit seen_wb = 0;
    logic [31:0] e_addr = {addr[31:5], 5'd0};
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_upd = upd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (stray) begin req_valid = 1'b1; req_addr = stray_addr; req_upd = 1'b0; end
    while (cyc < 64) begin
      cyc++;
      if (stray && !ack) check({tag, " R8 ready low while busy"}, 256'(req_ready), 256'(0));
      if (ack) break;
      if (wb_valid) begin
        if (!seen_wb) check({tag, " R4 wb offered in 2nd cycle"}, 256'(cyc), 256'(2));
        seen_wb = 1;
        check({tag, " R4/R5 wb_addr"}, 256'(wb_addr), 256'(e_addr));
        check({tag, " R4/R5 wb_data"}, wb_data, line_pat(int'(addr[8:5])));
        wb_ready = (wcnt == dly);
        wcnt++;
      end else wb_ready = 1'b0;
      @(negedge clk);
    end
    wb_ready = 1'b0;
    if (stray) check({tag, " R8 ready low at ack"}, 256'(req_ready), 256'(0));
    req_valid = 1'b0;
    check({tag, " R9 ack seen"}, 256'(ack), 256'(1));
    check({tag, " R3/R5 ack latency"}, 256'(cyc), 256'(e_wb ? 3 + dly : 2));
    check({tag, " R2 ack_hit"}, 256'(ack_hit), 256'(e_hit));
    check({tag, " R6 ack_wb"}, 256'(ack_wb), 256'(e_wb));
    check({tag, " R3/R6 wb used"}, 256'(seen_wb), 256'(e_wb));
    check({tag, " R7 ack_upd"}, 256'(ack_upd), 256'(upd));
    @(negedge clk);
    check({tag, " R9 ack single"}, 256'(ack), 256'(0));
  endtask

  task automatic preload(input int i, input logic v, input logic d);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = 4'(i); pl_tag = good_tag(i);
    pl_valid = v; pl_dirty = d; pl_data = line_pat(i);
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  function automatic logic [31:0] mk_addr(input int i, input bit wrong, input logic [4:0] ofs);
    return {(wrong ? WRONG_TAG : good_tag(i)), 4'(i), ofs};
  endfunction

  typedef struct packed {
    logic [3:0] idx; logic wrong; logic [4:0] ofs; logic upd;
    logic [3:0] dly; logic hit; logic wb;
  } vec_t;

  // line i: valid unless 3 or 7; dirty when odd
  localparam vec_t VECS [9] = '{
    '{4'd2,  1'b0, 5'd5,  1'b1, 4'd0, 1'b1, 1'b0},  // R3 clean hit
    '{4'd5,  1'b0, 5'd0,  1'b0, 4'd0, 1'b1, 1'b1},  // R4 dirty, ready at once
    '{4'd9,  1'b0, 5'd31, 1'b1, 4'd3, 1'b1, 1'b1},  // R5 dirty, ready delayed
    '{4'd4,  1'b1, 5'd7,  1'b1, 4'd0, 1'b0, 1'b0},  // R6 tag mismatch
    '{4'd3,  1'b0, 5'd1,  1'b0, 4'd0, 1'b0, 1'b0},  // R2 invalid dirty line misses
    '{4'd2,  1'b0, 5'd9,  1'b0, 4'd0, 1'b0, 1'b0},  // R3 line now invalid
    '{4'd5,  1'b0, 5'd2,  1'b1, 4'd0, 1'b0, 1'b0},  // R5 valid+dirty cleared
    '{4'd4,  1'b0, 5'd3,  1'b0, 4'd0, 1'b1, 1'b0},  // R6 miss left line 4 intact
    '{4'd11, 1'b0, 5'd4,  1'b0, 4'd7, 1'b1, 1'b1}   // R5 long wait
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 256'(req_ready), 256'(1));
    check("R1 ack", 256'(ack), 256'(0));
    check("R1 wb_valid", 256'(wb_valid), 256'(0));
    rst_n = 1'b1;
    op(mk_addr(6, 0, 0), 1'b1, 0, 1'b0, 1'b0, 0, '0, "R1 all invalid");
    // R10 preload
    for (int i = 0; i < 16; i++) preload(i, (i != 3 && i != 7), i[0]);
    foreach (VECS[n]) begin
      op(mk_addr(int'(VECS[n].idx), VECS[n].wrong, VECS[n].ofs), VECS[n].upd,
         int'(VECS[n].dly), VECS[n].hit, VECS[n].wb, 0, '0, $sformatf("vec%0d", n));
    end
    // R8 request held during a writeback is not taken; line 0 stays valid
    op(mk_addr(13, 0, 0), 1'b1, 4, 1'b1, 1'b1, 1, mk_addr(0, 0, 0), "R8 busy");
    op(mk_addr(0, 0, 0), 1'b0, 0, 1'b1, 1'b0, 0, '0, "R8 line0 kept");
    // R10 preload refills an invalidated line
    preload(2, 1'b1, 1'b1);
    op(mk_addr(2, 0, 12), 1'b1, 2, 1'b1, 1'b1, 0, '0, "R10 reload");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule